// File: doc/BRIEF.md
# I2C Target Address-Match Receiver

This block is the receive side of an I2C target. It watches the SDA and SCL lines, which reach it unsynchronised, and samples them on the system clock. Each line passes through a synchroniser and a short glitch filter. From the filtered lines the block detects START and STOP conditions and shifts in bytes on rising SCL. It then decides whether the first byte after a START addresses this device. The comparison uses a host-supplied compare value, the general call byte, or a two-step 10-bit sequence. A matched byte is acknowledged by pulling SDA low through the ninth clock.

Every accepted byte, address or data, lands in a single-entry receive buffer. The host drains this buffer over a valid/ready handshake. Back-pressure works like this: while the buffer is still full, any further byte the bus delivers is refused with a NACK and dropped, and the overflow flag records that a byte was lost. An interrupt pulse follows each byte the block has claimed. For 10-bit addressing the host rewrites the compare value between address bytes, prompted by an update-address flag. A hold request tells a separate clock-stretching block when SCL should be held low. The block does not drive SCL itself, and it sends no read data: during a read it leaves SDA released.

Top module: `i2c_tgt_rx`

## Requirements
- R1: After reset, and while `enable` is low, `start_seen` and `stop_seen` are 0. A START (SDA falling while SCL is high) sets `start_seen` and clears `stop_seen`. A STOP (SDA rising while SCL is high) does the opposite.
- R2: In 7-bit mode (`ten_bit`=0), a first byte after START that is not 0x00 and whose bits [7:1] equal `own_addr[7:1]` is accepted. Accepted means: SDA is pulled low (ACK) while SCL is high for the ninth bit, `rx_data` takes the byte, `rx_valid` rises, `is_data`=0, and `rw` takes bit 0 of the byte (1 = read).
- R3: A first byte that does not match gets no ACK, no buffer load and no `irq`. All further bytes are ignored until the next START.
- R4: After a write-address match, every data byte is acknowledged and loaded with `is_data`=1. Each byte the block claims produces exactly one one-cycle `irq` pulse, shortly after the ninth SCL falling edge.
- R5: A byte that would otherwise be claimed, arriving while `rx_valid` or `ovf` is 1, gets no ACK and leaves `rx_data` unchanged, but still produces an `irq` pulse. If `rx_valid` was 1, `ovf` is set. `ovf` clears only on `ovf_clr`.
- R6: `rx_valid` clears in the cycle after `rx_valid` and `rx_ready` are both high. `rx_data` changes only when a byte is loaded.
- R7: A first byte of 0x00 is acknowledged as a general call only when `gc_en`=1. In 10-bit mode, a general call does not set `upd_addr`, and the following bytes are received as data.
- R8: In 10-bit mode, a first byte of the form 11110xx0 whose bits [7:1] equal `own_addr[7:1]` is acknowledged and sets `upd_addr`. `upd_addr` clears on `addr_we`. The next byte must equal all 8 bits of `own_addr` to be acknowledged, and it sets `upd_addr` again. A later byte 11110xx1 after a repeated START is accepted as a read.
- R9: `hold_req` is 1 whenever `upd_addr` is 1. It is also 1 when `stretch_en`=1 and an unread data byte is in the buffer.
- R10: During a read the block leaves SDA released. If the master NACKs (SDA high at the ninth rising SCL), `rw` clears, no `irq` is raised, and bytes are ignored until the next START.
- R11: A STOP returns the block to idle and clears `rw`. A 10-bit read is then no longer accepted until the full 10-bit write sequence has been repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low clears all state and flags |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| sda_oe | output | 1 | 1 = pull SDA low (ACK) |
| own_addr | input | 8 | Compare value; bits [7:1] for first bytes, all 8 bits for the 10-bit second byte |
| addr_we | input | 1 | Pulse: host has rewritten `own_addr` |
| ten_bit | input | 1 | 1 = 10-bit addressing |
| gc_en | input | 1 | 1 = accept the general call byte |
| stretch_en | input | 1 | 1 = request a hold while a received data byte is unread |
| rx_data | output | 8 | Receive buffer contents |
| rx_valid | output | 1 | Buffer full |
| rx_ready | input | 1 | Host takes the buffer when high together with `rx_valid` |
| ovf | output | 1 | A byte was dropped while the buffer was full |
| ovf_clr | input | 1 | Pulse: clears `ovf` |
| is_data | output | 1 | 1 = buffer holds a data byte, 0 = an address byte |
| rw | output | 1 | R/W bit of the last matched address |
| start_seen | output | 1 | START was the last condition seen |
| stop_seen | output | 1 | STOP was the last condition seen |
| upd_addr | output | 1 | Host must rewrite `own_addr` (10-bit sequence) |
| hold_req | output | 1 | Request to the stretching block to hold SCL low |
| irq | output | 1 | One-cycle pulse per claimed byte |

## Verification
A wrong bit counter or wrong state register shows up within one byte time. The ACK lands on the wrong clock, or it is missing, and a single transfer exposes that. The buffer flags and the interrupt count also stop matching the reference by that byte's ninth clock. A wrong overflow or armed-read flag is silent until the next byte, or the next 10-bit read, that depends on it. The bench therefore always follows such events with a further byte. The outputs are compared with a behavioural model on every settled clock, so a flag that drifts is caught within the filter latency of the bus edge that caused it.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W  = 8;
  localparam int BCNT_W  = 4;
  localparam logic [4:0] TEN_PREFIX = 5'b11110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR2,
    ST_RX,
    ST_TX
  } tgt_state_e;

  typedef struct packed {
    logic       hit;
    logic       upd;
    logic       rw;
    logic       is_data;
    logic       arm;
    tgt_state_e nxt;
  } tgt_eval_t;
endpackage

// File: rtl/i2c_tgt_deglitch.sv
module i2c_tgt_deglitch #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;
  logic                   lvl_q, rise_q, fall_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= '1;
      lvl_q  <= 1'b1;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      if ((&hist_q) && !lvl_q) begin
        lvl_q  <= 1'b1;
        rise_q <= 1'b1;
      end else if (!(|hist_q) && lvl_q) begin
        lvl_q  <= 1'b0;
        fall_q <= 1'b1;
      end
    end
  end

  assign lvl_o  = lvl_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;
endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond (
  input  logic scl_lvl,
  input  logic sda_rise,
  input  logic sda_fall,
  output logic start_p,
  output logic stop_p
);
  assign start_p = sda_fall & scl_lvl;
  assign stop_p  = sda_rise & scl_lvl;
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic [BYTE_W-1:0] own_addr,
  input  logic              addr_we,
  input  logic              ten_bit,
  input  logic              gc_en,
  input  logic              rx_ready,
  input  logic              ovf_clr,
  output logic              sda_drv,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              ovf,
  output logic              is_data,
  output logic              rw,
  output logic              start_seen,
  output logic              stop_seen,
  output logic              upd_addr,
  output logic              irq
);
  localparam logic [BCNT_W-1:0] ACK_SLOT = BCNT_W'(BYTE_W);
  localparam logic [BCNT_W-1:0] END_SLOT = BCNT_W'(BYTE_W + 1);

  tgt_state_e        state_q, nxt_q;
  logic [BCNT_W-1:0] bcnt_q;
  logic [BYTE_W-1:0] sr_q;
  logic              armed_q, irq_pend_q;
  tgt_eval_t         ev;
  logic              blocked;

  // Byte classification at the end of the eighth bit
  always_comb begin
    ev     = '0;
    ev.nxt = ST_IDLE;
    case (state_q)
      ST_ADDR: begin
        if (sr_q == '0) begin
          if (gc_en) begin
            ev.hit = 1'b1;
            ev.nxt = ST_RX;
          end
        end else if (ten_bit) begin
          if (sr_q[BYTE_W-1:BYTE_W-5] == TEN_PREFIX &&
              sr_q[BYTE_W-1:1] == own_addr[BYTE_W-1:1]) begin
            if (!sr_q[0]) begin
              ev.hit = 1'b1;
              ev.upd = 1'b1;
              ev.nxt = ST_ADDR2;
            end else if (armed_q) begin
              ev.hit = 1'b1;
              ev.rw  = 1'b1;
              ev.nxt = ST_TX;
            end
          end
        end else if (sr_q[BYTE_W-1:1] == own_addr[BYTE_W-1:1]) begin
          ev.hit = 1'b1;
          ev.rw  = sr_q[0];
          ev.nxt = sr_q[0] ? ST_TX : ST_RX;
        end
      end
      ST_ADDR2: begin
        if (sr_q == own_addr) begin
          ev.hit = 1'b1;
          ev.upd = 1'b1;
          ev.arm = 1'b1;
          ev.nxt = ST_RX;
        end
      end
      ST_RX: begin
        ev.hit     = 1'b1;
        ev.is_data = 1'b1;
        ev.nxt     = ST_RX;
      end
      default: ;
    endcase
  end

  assign blocked = rx_valid | ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      nxt_q      <= ST_IDLE;
      bcnt_q     <= '0;
      sr_q       <= '0;
      armed_q    <= 1'b0;
      irq_pend_q <= 1'b0;
      sda_drv    <= 1'b0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      ovf        <= 1'b0;
      is_data    <= 1'b0;
      rw         <= 1'b0;
      start_seen <= 1'b0;
      stop_seen  <= 1'b0;
      upd_addr   <= 1'b0;
      irq        <= 1'b0;
    end else if (!enable) begin
      state_q    <= ST_IDLE;
      nxt_q      <= ST_IDLE;
      bcnt_q     <= '0;
      sr_q       <= '0;
      armed_q    <= 1'b0;
      irq_pend_q <= 1'b0;
      sda_drv    <= 1'b0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      ovf        <= 1'b0;
      is_data    <= 1'b0;
      rw         <= 1'b0;
      start_seen <= 1'b0;
      stop_seen  <= 1'b0;
      upd_addr   <= 1'b0;
      irq        <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (ovf_clr)              ovf      <= 1'b0;
      if (addr_we)              upd_addr <= 1'b0;

      if (start_p) begin
        start_seen <= 1'b1;
        stop_seen  <= 1'b0;
        state_q    <= ST_ADDR;
        bcnt_q     <= '0;
        rw         <= 1'b0;
        sda_drv    <= 1'b0;
        irq_pend_q <= 1'b0;
      end else if (stop_p) begin
        start_seen <= 1'b0;
        stop_seen  <= 1'b1;
        state_q    <= ST_IDLE;
        bcnt_q     <= '0;
        rw         <= 1'b0;
        sda_drv    <= 1'b0;
        armed_q    <= 1'b0;
        irq_pend_q <= 1'b0;
      end else if (state_q != ST_IDLE) begin
        if (scl_rise) begin
          if (bcnt_q < ACK_SLOT) begin
            sr_q   <= {sr_q[BYTE_W-2:0], sda_lvl};
            bcnt_q <= bcnt_q + 1'b1;
          end else if (bcnt_q == ACK_SLOT) begin
            if (state_q == ST_TX && sda_lvl) begin
              // master refused the byte: drop back and wait for START
              state_q    <= ST_IDLE;
              rw         <= 1'b0;
              irq_pend_q <= 1'b0;
              bcnt_q     <= '0;
            end else begin
              bcnt_q <= END_SLOT;
            end
          end
        end
        if (scl_fall) begin
          if (bcnt_q == ACK_SLOT) begin
            if (state_q == ST_TX) begin
              irq_pend_q <= 1'b1;
              nxt_q      <= ST_TX;
            end else if (ev.hit) begin
              irq_pend_q <= 1'b1;
              if (blocked) begin
                if (rx_valid) ovf <= 1'b1;
                nxt_q <= (state_q == ST_RX) ? ST_RX : ST_IDLE;
              end else begin
                rx_data  <= sr_q;
                rx_valid <= 1'b1;
                is_data  <= ev.is_data;
                sda_drv  <= 1'b1;
                nxt_q    <= ev.nxt;
                if (ev.upd)      upd_addr <= 1'b1;
                if (ev.arm)      armed_q  <= 1'b1;
                if (!ev.is_data) rw       <= ev.rw;
              end
            end else begin
              nxt_q <= ST_IDLE;
            end
          end else if (bcnt_q == END_SLOT) begin
            sda_drv    <= 1'b0;
            irq        <= irq_pend_q;
            irq_pend_q <= 1'b0;
            state_q    <= nxt_q;
            bcnt_q     <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_tgt_rx.sv
module i2c_tgt_rx
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [BYTE_W-1:0] own_addr,
  input  logic              addr_we,
  input  logic              ten_bit,
  input  logic              gc_en,
  input  logic              stretch_en,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              ovf,
  input  logic              ovf_clr,
  output logic              is_data,
  output logic              rw,
  output logic              start_seen,
  output logic              stop_seen,
  output logic              upd_addr,
  output logic              hold_req,
  output logic              irq
);
  localparam int NLINES = 2;
  localparam int IDX_SCL = 0;
  localparam int IDX_SDA = 1;

  logic [NLINES-1:0] raw, lvl, rise, fall;
  logic              start_p, stop_p;

  assign raw[IDX_SCL] = scl_i;
  assign raw[IDX_SDA] = sda_i;

  generate
    for (genvar g = 0; g < NLINES; g++) begin : g_line
      i2c_tgt_deglitch #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_LEN   (FILT_LEN)
      ) u_flt (
        .clk   (clk),
        .rst_n (rst_n),
        .line_i(raw[g]),
        .lvl_o (lvl[g]),
        .rise_o(rise[g]),
        .fall_o(fall[g])
      );
    end
  endgenerate

  i2c_tgt_cond u_cond (
    .scl_lvl (lvl[IDX_SCL]),
    .sda_rise(rise[IDX_SDA]),
    .sda_fall(fall[IDX_SDA]),
    .start_p (start_p),
    .stop_p  (stop_p)
  );

  i2c_tgt_engine u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .scl_rise  (rise[IDX_SCL]),
    .scl_fall  (fall[IDX_SCL]),
    .sda_lvl   (lvl[IDX_SDA]),
    .start_p   (start_p),
    .stop_p    (stop_p),
    .own_addr  (own_addr),
    .addr_we   (addr_we),
    .ten_bit   (ten_bit),
    .gc_en     (gc_en),
    .rx_ready  (rx_ready),
    .ovf_clr   (ovf_clr),
    .sda_drv   (sda_oe),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .ovf       (ovf),
    .is_data   (is_data),
    .rw        (rw),
    .start_seen(start_seen),
    .stop_seen (stop_seen),
    .upd_addr  (upd_addr),
    .irq       (irq)
  );

  assign hold_req = upd_addr | (stretch_en & rx_valid & is_data);
endmodule

// File: rtl/i2c_tgt_rx_chk.sv
module i2c_tgt_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       sda_oe,
  input logic [7:0] rx_data,
  input logic       rx_valid,
  input logic       ovf,
  input logic       ovf_clr,
  input logic       start_seen,
  input logic       stop_seen,
  input logic       upd_addr,
  input logic       hold_req,
  input logic       irq
);
  // R1: the two condition flags never both claim to be the latest
  assert_flags_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_seen && stop_seen));

  // R4: the interrupt is a single-cycle pulse
  assert_irq_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R5: ACK is only ever driven for a byte that was also placed in the buffer
  assert_ack_with_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $rose(rx_valid));

  // R5: overflow is sticky until the host clears it
  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr && enable) |=> ovf);

  // R6: buffer contents move only on a fresh load
  assert_data_on_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && !$stable(rx_data)) |-> $rose(rx_valid));

  // R8: the update request only appears together with an accepted address byte
  assert_upd_with_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_addr) |-> $rose(rx_valid));

  // R9: a pending address update always requests a hold
  assert_hold_on_upd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_addr |-> hold_req);
endmodule

bind i2c_tgt_rx i2c_tgt_rx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .sda_oe    (sda_oe),
  .rx_data   (rx_data),
  .rx_valid  (rx_valid),
  .ovf       (ovf),
  .ovf_clr   (ovf_clr),
  .start_seen(start_seen),
  .stop_seen (stop_seen),
  .upd_addr  (upd_addr),
  .hold_req  (hold_req),
  .irq       (irq)
);

// File: tb/i2c_tgt_rx_tb.sv
module i2c_tgt_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 24;
  localparam int Q    = 4;
  localparam int LAT  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [7:0] m_own = 8'h84;
  logic addr_we = 1'b0, m_ten = 1'b0, m_gcen = 1'b0, m_stretch = 1'b0;
  logic [7:0] rx_data;
  logic rx_valid, rx_ready = 1'b0, ovf, ovf_clr = 1'b0;
  logic is_data, rw, start_seen, stop_seen, upd_addr, hold_req, irq;
  logic sda_line;

  assign sda_line = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_tgt_rx u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .own_addr(m_own), .addr_we(addr_we), .ten_bit(m_ten),
    .gc_en(m_gcen), .stretch_en(m_stretch), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .ovf(ovf), .ovf_clr(ovf_clr), .is_data(is_data), .rw(rw),
    .start_seen(start_seen), .stop_seen(stop_seen), .upd_addr(upd_addr),
    .hold_req(hold_req), .irq(irq)
  );

  int checks = 0, errors = 0;
  int quiet = LAT;
  bit cmp_on = 1'b0;
  int irq_seen = 0;

  // behavioural reference state
  logic [7:0] m_data = 8'h00;
  logic m_valid = 0, m_ovf = 0, m_isdata = 0, m_rw = 0, m_start = 0, m_stop = 0, m_upd = 0;
  logic m_armed = 0, m_pend = 0;
  int   m_irq = 0;
  int   mst = 0, m_nxt = 0;   // 0 idle, 1 first addr, 2 second addr, 3 receive, 4 read

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (irq === 1'b1) irq_seen++;

  // per-clock comparison against the reference once outputs have settled
  always @(negedge clk) begin
    if (quiet > 0) quiet--;
    else if (cmp_on) begin
      chk({7'd0, start_seen}, {7'd0, m_start}, "R1 start_seen");
      chk({7'd0, stop_seen},  {7'd0, m_stop},  "R1 stop_seen");
      chk({7'd0, rx_valid},   {7'd0, m_valid}, "R6 rx_valid");
      chk(rx_data,            m_data,          "R6 rx_data");
      chk({7'd0, is_data},    {7'd0, m_isdata},"R4 is_data");
      chk({7'd0, ovf},        {7'd0, m_ovf},   "R5 ovf");
      chk({7'd0, rw},         {7'd0, m_rw},    "R10 rw");
      chk({7'd0, upd_addr},   {7'd0, m_upd},   "R8 upd_addr");
      chk({7'd0, hold_req},   {7'd0, m_upd | (m_stretch & m_valid & m_isdata)}, "R9 hold_req");
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic model_eval(input logic [7:0] b);
    logic hit = 0, upd = 0, rwv = 0, dat = 0, arm = 0;
    int nxt = 0;
    case (mst)
      1: begin
        if (b == 8'h00) begin
          if (m_gcen) begin hit = 1; nxt = 3; end
        end else if (m_ten) begin
          if (b[7:3] == 5'b11110 && b[7:1] == m_own[7:1]) begin
            if (!b[0]) begin hit = 1; upd = 1; nxt = 2; end
            else if (m_armed) begin hit = 1; rwv = 1; nxt = 4; end
          end
        end else if (b[7:1] == m_own[7:1]) begin
          hit = 1; rwv = b[0]; nxt = b[0] ? 4 : 3;
        end
      end
      2: if (b == m_own) begin hit = 1; upd = 1; arm = 1; nxt = 3; end
      3: begin hit = 1; dat = 1; nxt = 3; end
      default: ;
    endcase
    if (!hit) begin m_nxt = 0; return 1'b0; end
    m_pend = 1;
    if (m_valid || m_ovf) begin
      if (m_valid) m_ovf = 1;
      m_nxt = (mst == 3) ? 3 : 0;
      return 1'b0;
    end
    m_valid = 1; m_data = b; m_isdata = dat; m_nxt = nxt;
    if (upd) m_upd = 1;
    if (arm) m_armed = 1;
    if (!dat) m_rw = rwv;
    return 1'b1;
  endfunction

  task automatic bus_start();
    sda_m = 1; wait_n(HALF); scl_m = 1; wait_n(HALF);
    sda_m = 0; quiet = LAT;
    m_start = 1; m_stop = 0; mst = 1; m_rw = 0; m_pend = 0;
    wait_n(HALF); scl_m = 0; wait_n(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; wait_n(HALF); scl_m = 1; wait_n(HALF);
    sda_m = 1; quiet = LAT;
    m_stop = 1; m_start = 0; mst = 0; m_rw = 0; m_armed = 0; m_pend = 0;
    wait_n(HALF);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
    logic ack_act;
    logic dummy;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_n(HALF); scl_m = 1; wait_n(HALF); scl_m = 0;
      quiet = LAT;
      if (i == 0) dummy = model_eval(b);
      wait_n(Q);
    end
    sda_m = 1; wait_n(HALF); scl_m = 1; wait_n(HALF/2);
    ack_act = ~sda_line;
    wait_n(HALF/2); scl_m = 0; quiet = LAT;
    if (mst != 0) begin
      if (m_pend) m_irq++;
      m_pend = 0; mst = m_nxt;
    end
    wait_n(HALF);
    chk({7'd0, ack_act}, {7'd0, exp_ack}, {tag, " ack"});
    chk(8'(irq_seen), 8'(m_irq), {tag, " irq count"});
  endtask

  task automatic read_byte(input logic master_nack);
    logic drove;
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1; wait_n(HALF); scl_m = 1; wait_n(HALF/2);
      drove = ~sda_line;
      chk({7'd0, drove}, 8'd0, "R10 sda released in read");
      wait_n(HALF/2); scl_m = 0; wait_n(Q);
    end
    sda_m = master_nack; wait_n(HALF); scl_m = 1; quiet = LAT;
    if (master_nack) begin mst = 0; m_rw = 0; end
    wait_n(HALF); scl_m = 0; quiet = LAT;
    if (!master_nack) m_irq++;
    wait_n(Q); sda_m = 1; wait_n(HALF);
    chk(8'(irq_seen), 8'(m_irq), "R10 irq count");
  endtask

  task automatic read_buf();
    @(negedge clk); rx_ready = 1; m_valid = 0; quiet = LAT;
    @(negedge clk); rx_ready = 0;
    wait_n(2);
  endtask

  task automatic write_own(input logic [7:0] v);
    @(negedge clk); m_own = v; addr_we = 1; m_upd = 0; quiet = LAT;
    @(negedge clk); addr_we = 0;
    wait_n(2);
  endtask

  task automatic pulse_ovf_clr();
    @(negedge clk); ovf_clr = 1; m_ovf = 0; quiet = LAT;
    @(negedge clk); ovf_clr = 0;
    wait_n(2);
  endtask

  initial begin : watchdog
    wait_n(150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    wait_n(5);
    rst_n = 1;
    wait_n(LAT);
    // R1: reset state
    chk({start_seen, stop_seen, rx_valid, ovf, upd_addr, irq, sda_oe, rw}, 8'd0, "R1 reset state");
    cmp_on = 1;

    // R2, R4, R5, R6: 7-bit write with back-pressure
    bus_start();
    send_byte(8'h84, 1, "R2 own address");
    read_buf();
    send_byte(8'h5A, 1, "R4 data byte");
    send_byte(8'h3C, 0, "R5 buffer full");
    chk(rx_data, 8'h5A, "R5 data kept");
    read_buf();
    send_byte(8'h11, 0, "R5 overflow pending");
    pulse_ovf_clr();
    send_byte(8'h22, 1, "R5 after clear");
    read_buf();
    bus_stop();

    // R3: address mismatch, later bytes ignored
    bus_start();
    send_byte(8'h90, 0, "R3 mismatch");
    send_byte(8'h84, 0, "R3 ignored until start");
    bus_stop();

    // R7: general call gated by enable bit
    bus_start();
    send_byte(8'h00, 0, "R7 gc disabled");
    bus_stop();
    m_gcen = 1;
    bus_start();
    send_byte(8'h00, 1, "R7 gc enabled");
    read_buf();
    bus_stop();

    // R10: read address, master NACK ends transfer
    bus_start();
    send_byte(8'h85, 1, "R10 read address");
    chk({7'd0, rw}, 8'd1, "R10 rw set");
    read_buf();
    read_byte(1'b1);
    chk({7'd0, rw}, 8'd0, "R10 rw cleared on nack");
    send_byte(8'h84, 0, "R10 ignored after nack");
    bus_stop();

    // R9: stretch request while a data byte waits
    m_stretch = 1;
    bus_start();
    send_byte(8'h84, 1, "R9 address");
    read_buf();
    send_byte(8'h77, 1, "R9 data");
    chk({7'd0, hold_req}, 8'd1, "R9 hold with data waiting");
    read_buf();
    chk({7'd0, hold_req}, 8'd0, "R9 hold released");
    bus_stop();
    m_stretch = 0;

    // R8: 10-bit write then read through repeated start
    m_ten = 1;
    write_own(8'hF6);
    bus_start();
    send_byte(8'hF6, 1, "R8 high address byte");
    chk({7'd0, upd_addr}, 8'd1, "R8 update requested");
    read_buf();
    write_own(8'h3C);
    send_byte(8'h3C, 1, "R8 low address byte");
    read_buf();
    write_own(8'hF6);
    send_byte(8'h99, 1, "R8 data after 10-bit match");
    read_buf();
    bus_start();
    send_byte(8'hF7, 1, "R8 10-bit read");
    chk({7'd0, rw}, 8'd1, "R8 read flag");
    read_buf();
    read_byte(1'b0);
    bus_stop();

    // R11: after stop a 10-bit read needs the full sequence again
    bus_start();
    send_byte(8'hF7, 0, "R11 read refused after stop");
    bus_stop();

    // R7: general call in 10-bit mode needs no update
    bus_start();
    send_byte(8'h00, 1, "R7 gc 10-bit");
    chk({7'd0, upd_addr}, 8'd0, "R7 no update on gc");
    read_buf();
    send_byte(8'h42, 1, "R7 data after gc");
    read_buf();
    bus_stop();

    // R1: disable clears condition flags
    chk({7'd0, stop_seen}, 8'd1, "R1 stop seen");
    @(negedge clk); enable = 0; quiet = LAT;
    m_start = 0; m_stop = 0; m_valid = 0; m_ovf = 0; m_isdata = 0; m_rw = 0;
    m_upd = 0; m_armed = 0; m_data = 8'h00; mst = 0;
    wait_n(4);
    chk({7'd0, stop_seen}, 8'd0, "R1 cleared by disable");
    enable = 1;
    wait_n(LAT + 4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule